// File: doc/BRIEF.md
# System Controller Register Block

This block is a small bank of 32-bit registers that a processor reaches over a simple word-wide register bus. The bus has a byte address, write data, a write strobe, read data and an error flag. The bank holds a general-purpose pin port, a debug scratch word with a latch that marks "debug writes done" and cannot be cleared, and a reconfiguration command word that can ask the system to shut down. It also holds three constant words giving the clock rate, a capability mask and a system identifier. Writing the identifier word does not change it. Instead the write asks the system to reset.

The external input pins pass through a two-flop synchronizer before software can see them. During reset, the input word shows a strap constant in place of the pins. Shutdown and reset requests leave the block as one-cycle pulses, registered from the write strobe, for a system power or reset manager to act on. Read data and the error flag follow the address combinationally, so a read finishes in the same cycle that the address is presented.

Top module: `sysctl_regs`

## Requirements
- R1: The register index is byte address bits [6:2]. Only word-aligned accesses are valid: when address bits [1:0] are not zero, the error flag is high, read data is 0 and a write has no effect.
- R2: Word 0 (byte 0x00) reads the input pins through two register stages. A pin change that is stable before a clock edge shows on reads after the second edge. While reset is held, word 0 reads the strap parameter (default 0x00000001). Writes to word 0 are ignored.
- R3: Word 1 (byte 0x04, pin output) and word 2 (byte 0x08, interrupt enable) read back the last value written to them and reset to 0. Word 1 drives the output pins.
- R4: Word 16 (byte 0x40) reads 0x00000001, meaning ready. A write to it whose bits [15:0] equal 0x000E raises the shutdown request for exactly the one cycle after the write edge. A write with any other value raises nothing.
- R5: Word 20 (byte 0x50) is a scratch word that resets to 0 and reads back the last value written.
- R6: Word 21 (byte 0x54) reads 0 after reset. Any write to it, whatever the data and including 0, makes it read 1, and it keeps reading 1 until reset.
- R7: Words 29, 30 and 31 (bytes 0x74, 0x78, 0x7C) read 80000000, 0 and 0x10014D31 by default. Writes to words 29 and 30 are ignored.
- R8: A write to word 31 raises the reset request for exactly the one cycle after the write edge and leaves the identifier unchanged. No other write raises it.
- R9: An aligned address that selects none of the words 0, 1, 2, 16, 20, 21, 29, 30 or 31 raises the error flag and reads 0, and a write to it changes no register. Mapped aligned addresses leave the error flag low.
- R10: After reset, words 1, 2, 20 and 21 read 0, the output pins are 0 and both request pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (7) | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for the current address |
| bus_err | output | 1 | High when the current address is unmapped or misaligned |
| gpio_in | input | GPIO_W (32) | External input pins, asynchronous |
| gpio_out | output | GPIO_W (32) | Output pins |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The pulse assertions assume that each write strobe lasts one cycle and is followed by at least one idle cycle. The bench's write task always raises the strobe for a single cycle and then drops it, so two writes are never back to back. The assertions also assume that address and data are stable around the clock edge. The bench changes every bus input and the input pins only on the falling edge. The synchronizer check depends on the bench holding the pins steady for several cycles before each change, so that the two-edge latency can be counted exactly.

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter int          ADDR_W = 7,
  parameter int          GPIO_W = 32,
  parameter logic [31:0] CLK_HZ = 32'd80000000,
  parameter logic [31:0] CAPS   = 32'h0000_0000,
  parameter logic [31:0] SYS_ID = 32'h1001_4D31,
  parameter logic [GPIO_W-1:0] STRAP = GPIO_W'(1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic [GPIO_W-1:0] gpio_in,
  output logic [GPIO_W-1:0] gpio_out,
  output logic              shutdown_req,
  output logic              reset_req
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] W_GIN   = IDX_W'(0);
  localparam logic [IDX_W-1:0] W_GOUT  = IDX_W'(1);
  localparam logic [IDX_W-1:0] W_GIEN  = IDX_W'(2);
  localparam logic [IDX_W-1:0] W_CMD   = IDX_W'(16);
  localparam logic [IDX_W-1:0] W_SCR   = IDX_W'(20);
  localparam logic [IDX_W-1:0] W_LOCK  = IDX_W'(21);
  localparam logic [IDX_W-1:0] W_FREQ  = IDX_W'(29);
  localparam logic [IDX_W-1:0] W_CAPS  = IDX_W'(30);
  localparam logic [IDX_W-1:0] W_ID    = IDX_W'(31);
  localparam logic [15:0]      OFF_CODE = 16'h000E;

  logic [IDX_W-1:0]  widx;
  logic              aligned, wr;
  logic [GPIO_W-1:0] gin_s1, gin_s2, gien_q;
  logic [31:0]       scratch_q;
  logic              lock_q;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr      = bus_we && aligned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gin_s1 <= STRAP;
      gin_s2 <= STRAP;
    end else begin
      gin_s1 <= gpio_in;
      gin_s2 <= gin_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpio_out  <= '0;
      gien_q    <= '0;
      scratch_q <= '0;
      lock_q    <= 1'b0;
    end else if (wr) begin
      if (widx == W_GOUT) gpio_out  <= bus_wdata[GPIO_W-1:0];
      if (widx == W_GIEN) gien_q    <= bus_wdata[GPIO_W-1:0];
      if (widx == W_SCR)  scratch_q <= bus_wdata;
      if (widx == W_LOCK) lock_q    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
    end else begin
      shutdown_req <= wr && (widx == W_CMD) && (bus_wdata[15:0] == OFF_CODE);
      reset_req    <= wr && (widx == W_ID);
    end
  end

  always_comb begin
    bus_rdata = '0;
    bus_err   = 1'b0;
    if (!aligned) begin
      bus_err = 1'b1;
    end else begin
      unique case (widx)
        W_GIN:   bus_rdata = 32'(gin_s2);
        W_GOUT:  bus_rdata = 32'(gpio_out);
        W_GIEN:  bus_rdata = 32'(gien_q);
        W_CMD:   bus_rdata = 32'h0000_0001;
        W_SCR:   bus_rdata = scratch_q;
        W_LOCK:  bus_rdata = {31'b0, lock_q};
        W_FREQ:  bus_rdata = CLK_HZ;
        W_CAPS:  bus_rdata = CAPS;
        W_ID:    bus_rdata = SYS_ID;
        default: bus_err   = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int          ADDR_W = 7,
  parameter int          GPIO_W = 32,
  parameter logic [31:0] SYS_ID = 32'h1001_4D31
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic [GPIO_W-1:0] gpio_out,
  input logic              shutdown_req,
  input logic              reset_req,
  input logic              lock_q
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(16 * 4);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(21 * 4);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(31 * 4);

  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> lock_q);
  a_r6_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_LOCK) |=> lock_q);
  a_r4_shutdown_cause: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> ($past(bus_we) && $past(bus_addr) == A_CMD));
  a_r4_shutdown_single: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);
  a_r8_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> ($past(bus_we) && $past(bus_addr) == A_ID));
  a_r8_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  a_r9_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == 32'h0));
  a_r7_id_const: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_ID) |-> (!bus_err && bus_rdata == SYS_ID));
  a_r3_gpio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_we) |-> $stable(gpio_out));
endmodule

bind sysctl_regs sysctl_regs_chk #(.ADDR_W(ADDR_W), .GPIO_W(GPIO_W), .SYS_ID(SYS_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .bus_err(bus_err), .gpio_out(gpio_out),
  .shutdown_req(shutdown_req), .reset_req(reset_req), .lock_q(lock_q)
);

// File: tb/sim_sysctl_regs.sv
module sim_sysctl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        err;
  logic [31:0] pins = 32'hFFFF_0000;
  logic [31:0] gout;
  logic        sd, rr;
  logic        sd_seen, rr_seen;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
    .bus_rdata(rdata), .bus_err(err), .gpio_in(pins), .gpio_out(gout),
    .shutdown_req(sd), .reset_req(rr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    sd_seen = sd; rr_seen = rr;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1;
    d = rdata; e = err;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    addr = 7'h00; #1;
    check("R2 strap in reset", rdata, 32'h1);
    rst_n = 1'b1;
    rd(7'h04, d, e); check("R10 gpio_out reset", d, 0);
    rd(7'h08, d, e); check("R10 inten reset", d, 0);
    rd(7'h50, d, e); check("R10 scratch reset", d, 0);
    rd(7'h54, d, e); check("R10 lock reset", d, 0);
    check("R10 pins reset", gout, 0);
    check("R10 pulses reset", {30'b0, sd, rr}, 0);
  endtask

  task automatic t_gpio_in();
    logic [31:0] d; logic e;
    pins = 32'h0000_1234;
    repeat (3) @(negedge clk);
    addr = 7'h00; pins = 32'h0000_CAFE; #1;
    check("R2 before edge", rdata, 32'h1234);
    @(negedge clk); #1;
    check("R2 after one edge", rdata, 32'h1234);
    @(negedge clk); #1;
    check("R2 after two edges", rdata, 32'hCAFE);
    wr(7'h00, 32'h0);
    rd(7'h00, d, e); check("R2 write ignored", d, 32'hCAFE);
    check("R9 word0 mapped", {31'b0, e}, 0);
  endtask

  task automatic t_gpio_out();
    logic [31:0] d; logic e;
    wr(7'h04, 32'hA5A5_0F0F);
    rd(7'h04, d, e); check("R3 gpio_out readback", d, 32'hA5A5_0F0F);
    check("R3 pins driven", gout, 32'hA5A5_0F0F);
    wr(7'h08, 32'h0000_00FF);
    rd(7'h08, d, e); check("R3 inten readback", d, 32'hFF);
    rd(7'h04, d, e); check("R3 gpio_out kept", d, 32'hA5A5_0F0F);
  endtask

  task automatic t_cmd();
    logic [31:0] d; logic e;
    rd(7'h40, d, e); check("R4 ready", d, 32'h1);
    wr(7'h40, 32'hABCD_000E);
    check("R4 shutdown pulse", {31'b0, sd_seen}, 1);
    check("R8 no reset on cmd", {31'b0, rr_seen}, 0);
    @(negedge clk); check("R4 pulse one cycle", {31'b0, sd}, 0);
    wr(7'h40, 32'h0000_000F);
    check("R4 other code", {31'b0, sd_seen}, 0);
    wr(7'h40, 32'h000E_0000);
    check("R4 upper bits only", {31'b0, sd_seen}, 0);
    wr(7'h41, 32'h0000_000E);
    check("R1 misaligned cmd", {31'b0, sd_seen}, 0);
  endtask

  task automatic t_scratch();
    logic [31:0] d; logic e;
    wr(7'h50, 32'hDEAD_BEEF);
    rd(7'h50, d, e); check("R5 scratch", d, 32'hDEAD_BEEF);
    wr(7'h51, 32'h1111_1111);
    rd(7'h50, d, e); check("R1 misaligned write ignored", d, 32'hDEAD_BEEF);
    rd(7'h52, d, e);
    check("R1 misaligned read zero", d, 0);
    check("R1 misaligned err", {31'b0, e}, 1);
  endtask

  task automatic t_lock();
    logic [31:0] d; logic e;
    wr(7'h54, 32'h0);
    rd(7'h54, d, e); check("R6 lock on zero write", d, 1);
    wr(7'h54, 32'hFFFF_FFFE);
    rd(7'h54, d, e); check("R6 lock stays", d, 1);
  endtask

  task automatic t_const();
    logic [31:0] d; logic e;
    rd(7'h74, d, e); check("R7 freq", d, 32'd80000000);
    rd(7'h78, d, e); check("R7 caps", d, 0);
    wr(7'h74, 32'h1); wr(7'h78, 32'hFFFF_FFFF);
    rd(7'h74, d, e); check("R7 freq write ignored", d, 32'd80000000);
    rd(7'h78, d, e); check("R7 caps write ignored", d, 0);
    check("R9 caps mapped", {31'b0, e}, 0);
  endtask

  task automatic t_id();
    logic [31:0] d; logic e;
    rd(7'h7C, d, e); check("R7 id", d, 32'h1001_4D31);
    wr(7'h7C, 32'h0);
    check("R8 reset pulse", {31'b0, rr_seen}, 1);
    check("R8 no shutdown", {31'b0, sd_seen}, 0);
    @(negedge clk); check("R8 pulse one cycle", {31'b0, rr}, 0);
    rd(7'h7C, d, e); check("R8 id unchanged", d, 32'h1001_4D31);
  endtask

  task automatic t_unmapped();
    logic [31:0] d; logic e;
    rd(7'h0C, d, e);
    check("R9 word3 err", {31'b0, e}, 1); check("R9 word3 zero", d, 0);
    rd(7'h44, d, e); check("R9 word17 err", {31'b0, e}, 1);
    rd(7'h70, d, e); check("R9 word28 err", {31'b0, e}, 1);
    wr(7'h10, 32'h5555_5555);
    check("R9 no pulse", {30'b0, sd_seen, rr_seen}, 0);
    rd(7'h50, d, e); check("R9 scratch untouched", d, 32'hDEAD_BEEF);
    rd(7'h04, d, e); check("R9 gpio untouched", d, 32'hA5A5_0F0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_gpio_in();
    t_gpio_out();
    t_cmd();
    t_scratch();
    t_lock();
    t_const();
    t_id();
    t_unmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule